// File: doc/BRIEF.md
# Single-Channel Memory/Peripheral Transfer Engine

This block moves a programmed number of words between one peripheral and memory so that the processor does not have to copy them itself. Software loads a start address, a word count and a control word through a small register port. The peripheral then asks for service. The engine asks the processor for the system bus and waits for the grant. It then acknowledges the peripheral and, for each word, drives the memory address and either a write strobe or a read strobe.

Two bus-ownership styles are available. In burst style the bus is kept for back-to-back words as long as the peripheral keeps asking. In cycle-stealing style the bus is handed back after every word. Between words the peripheral's request is sampled again. When the count runs out, the engine drops its bus request and raises a completion interrupt. That interrupt stays up until software writes the control register.

Top module: `dmac_top`

## Requirements
- R1: A register access takes place only while `cs_i` is high. `sel_i` picks the register: 0 is the address register, 1 is the word count and 2 is control. Writes use `wr_i` and take effect at the next clock edge. Reads return the selected register on `rdata_o` in the same cycle. The control bits are: bit0 go (always reads 0), bit1 direction (0 = peripheral to memory, 1 = memory to peripheral), bit2 burst (1 = burst, 0 = cycle stealing), bit3 interrupt (read-only) and bit4 busy (read-only). When `cs_i` is low, `rdata_o` reads 0.
- R2: A control write with go=1 starts a transfer while the engine is idle and the count is nonzero, and busy then reads 1. If the count is zero, go is ignored and no bus request follows.
- R3: While busy, a peripheral request leads to `breq_o`. `dack_o` is high only while `bgnt_i` is high, and only after a cycle in which `breq_o` was high.
- R4: With direction 0 each word pulses `mem_wr_o`. With direction 1 each word pulses `mem_rd_o`. Either way `mem_addr_o` carries the address register during the pulse, and the pulse coincides with `dack_o`.
- R5: After each word the address register rises by one and the count falls by one.
- R6: On the word that brings the count to zero, the engine sets the interrupt, then drops `breq_o` and busy in the next cycle.
- R7: The interrupt stays high across idle cycles and across writes to other registers, until a control write clears it.
- R8: In burst style, while the peripheral keeps requesting and the grant stays high, words follow on consecutive cycles with `breq_o` held high.
- R9: In cycle-stealing style, `breq_o` is low in the cycle after every word.
- R10: Once the peripheral withdraws its request between words, no further word is transferred until it requests again. The count and address then hold their values.
- R11: `bus_oe_o` is high exactly while both `breq_o` and `bgnt_i` are high. The two memory strobes are never high together and occur only while `bus_oe_o` is high.
- R12: Register writes while busy are ignored, and this holds for all three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Register port select |
| wr_i | input | 1 | Register write enable |
| sel_i | input | 2 | Register selector |
| wdata_i | input | REG_W | Register write data |
| rdata_o | output | REG_W | Register read data |
| dreq_i | input | 1 | Peripheral service request |
| dack_o | output | 1 | Peripheral acknowledge, one per word |
| breq_o | output | 1 | System bus request to the processor |
| bgnt_i | input | 1 | System bus grant from the processor |
| bus_oe_o | output | 1 | Engine drives address and strobes (processor side floated) |
| mem_addr_o | output | ADDR_W | Memory address of the current word |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| eot_irq_o | output | 1 | Completion interrupt |

## Verification
The first run is a burst transfer into memory with the request held high throughout. Back-to-back strobes with no break in `breq_o` separate burst ownership from per-word release. The second run is a cycle-stealing transfer out of memory, which must give read strobes and a dead bus-request cycle after every word; this separates the two ownership styles and the two directions. The third run is a burst in which the request is withdrawn after two words. It shows that the request is sampled again between words, and register writes made during the pause show that they have no effect while the engine is busy. A go with a zero count and a sticky interrupt across unrelated writes cover the idle edge cases.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2,
        ST_XFER = 2'd3
    } dma_state_e;

    localparam int CTL_GO    = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_BURST = 2;
    localparam int CTL_IRQ   = 3;
    localparam int CTL_BUSY  = 4;

    typedef struct packed {
        logic to_dev;   // 1: memory read toward peripheral
        logic burst;    // 1: keep bus across words
    } dma_mode_t;

    function automatic logic [4:0] ctrl_word(input dma_mode_t m, input logic irq,
                                             input logic busy);
        logic [4:0] w;
        w            = '0;
        w[CTL_DIR]   = m.to_dev;
        w[CTL_BURST] = m.burst;
        w[CTL_IRQ]   = irq;
        w[CTL_BUSY]  = busy;
        return w;
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              busy_i,
    input  logic              word_done_i,
    output logic              start_o,
    output dma_mode_t         mode_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    dma_mode_t         mode_q;
    logic              irq_q;
    logic              write_hit;
    reg_sel_e          sel;

    assign sel       = reg_sel_e'(sel_i);
    assign write_hit = cs_i && wr_i && !busy_i;
    assign start_o   = write_hit && (sel == SEL_CTRL) && wdata_i[CTL_GO] && (cnt_q != '0);
    assign last_o    = (cnt_q == CNT_ONE);
    assign mode_o    = mode_q;
    assign addr_o    = addr_q;
    assign irq_o     = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            irq_q  <= 1'b0;
        end else if (write_hit) begin
            case (sel)
                SEL_ADDR:  addr_q <= wdata_i[ADDR_W-1:0];
                SEL_COUNT: cnt_q  <= wdata_i[CNT_W-1:0];
                SEL_CTRL: begin
                    mode_q.to_dev <= wdata_i[CTL_DIR];
                    mode_q.burst  <= wdata_i[CTL_BURST];
                    irq_q         <= 1'b0;
                end
                default: ;
            endcase
        end else if (word_done_i) begin
            addr_q <= addr_q + ADDR_ONE;
            cnt_q  <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) irq_q <= 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (cs_i) begin
            case (sel)
                SEL_ADDR:  rdata_o[ADDR_W-1:0] = addr_q;
                SEL_COUNT: rdata_o[CNT_W-1:0]  = cnt_q;
                SEL_CTRL:  rdata_o[4:0]        = ctrl_word(mode_q, irq_q, busy_i);
                default:   rdata_o             = '0;
            endcase
        end
    end

    // R5: each word steps address up and count down
    a_r5_word_step: assert property (@(posedge clk) disable iff (rst)
        word_done_i |=> (addr_q == $past(addr_q) + ADDR_ONE) && (cnt_q == $past(cnt_q) - CNT_ONE));

    // R6: last word raises the interrupt
    a_r6_irq_on_last: assert property (@(posedge clk) disable iff (rst)
        (word_done_i && last_o) |=> irq_q);

    // R7: interrupt held until a control write
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !(cs_i && wr_i && sel == SEL_CTRL)) |=> irq_q);

    // R12: writes while busy leave the registers alone
    a_r12_busy_lock: assert property (@(posedge clk) disable iff (rst)
        (busy_i && cs_i && wr_i && !word_done_i) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(mode_q)));

endmodule

// File: rtl/dmac_fsm.sv
module dmac_fsm
    import dmac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  dma_mode_t mode_i,
    input  logic      last_i,
    input  logic      dreq_i,
    input  logic      bgnt_i,
    output logic      busy_o,
    output logic      breq_o,
    output logic      dack_o,
    output logic      word_done_o
);

    dma_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i) state_d = ST_WAIT;
            ST_WAIT: if (dreq_i)  state_d = ST_REQ;
            ST_REQ:  if (bgnt_i)  state_d = ST_XFER;
            ST_XFER: begin
                if (!bgnt_i)                      state_d = ST_REQ;
                else if (last_i)                  state_d = ST_IDLE;
                else if (mode_i.burst && dreq_i)  state_d = ST_XFER;
                else                              state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign breq_o      = (state_q == ST_REQ) || (state_q == ST_XFER);
    assign dack_o      = (state_q == ST_XFER) && bgnt_i;
    assign word_done_o = dack_o;

    // R2: a start moves the engine out of idle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    // R3: acknowledge only after the bus was requested
    a_r3_ack_after_req: assert property (@(posedge clk) disable iff (rst)
        dack_o |-> $past(breq_o));

    // R6: final word releases the bus and ends busy
    a_r6_done_release: assert property (@(posedge clk) disable iff (rst)
        (word_done_o && last_i) |=> (!breq_o && !busy_o));

    // R8: burst keeps requesting while the peripheral asks
    a_r8_burst_hold: assert property (@(posedge clk) disable iff (rst)
        (word_done_o && mode_i.burst && dreq_i && !last_i) |=> breq_o);

    // R9: cycle stealing hands the bus back after each word
    a_r9_steal_gap: assert property (@(posedge clk) disable iff (rst)
        (word_done_o && !mode_i.burst) |=> !breq_o);

    // R10: no request on the bus without a peripheral request
    a_r10_recheck: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !dreq_i) |=> !breq_o);

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              dreq_i,
    output logic              dack_o,
    output logic              breq_o,
    input  logic              bgnt_i,
    output logic              bus_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wr_o,
    output logic              mem_rd_o,
    output logic              eot_irq_o
);

    logic      busy;
    logic      word_done;
    logic      start;
    logic      last;
    dma_mode_t mode;

    dmac_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W)
    ) regs_i (
        .clk         (clk),
        .rst         (rst),
        .cs_i        (cs_i),
        .wr_i        (wr_i),
        .sel_i       (sel_i),
        .wdata_i     (wdata_i),
        .rdata_o     (rdata_o),
        .busy_i      (busy),
        .word_done_i (word_done),
        .start_o     (start),
        .mode_o      (mode),
        .addr_o      (mem_addr_o),
        .last_o      (last),
        .irq_o       (eot_irq_o)
    );

    dmac_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .mode_i      (mode),
        .last_i      (last),
        .dreq_i      (dreq_i),
        .bgnt_i      (bgnt_i),
        .busy_o      (busy),
        .breq_o      (breq_o),
        .dack_o      (dack_o),
        .word_done_o (word_done)
    );

    assign bus_oe_o = breq_o && bgnt_i;
    assign mem_wr_o = word_done && !mode.to_dev;
    assign mem_rd_o = word_done &&  mode.to_dev;

    // R11: strobes exclusive and only while the engine owns the bus
    a_r11_strobe_owned: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o || mem_rd_o) |-> (bus_oe_o && $onehot0({mem_wr_o, mem_rd_o})));

    // R4: every strobe comes with the peripheral acknowledge
    a_r4_strobe_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o || mem_rd_o) |-> dack_o);

endmodule

// File: tb/dmac_top_tb_top.sv
module dmac_top_tb_top;

    localparam int AW = 16;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0, wr = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic [RW-1:0] wdata = '0;
    logic [RW-1:0] rdata;
    logic          dreq = 1'b0;
    logic          dack, breq, bus_oe, mem_wr, mem_rd, irq;
    logic          bgnt = 1'b0;
    logic [AW-1:0] mem_addr;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  words_seen = 0;
    bit  tb_burst = 1'b1;
    bit  prev_strobe = 1'b0;
    bit  reported = 1'b0;
    logic [AW:0] exp_q[$];   // {is_read, address}

    always #5 clk = ~clk;

    // processor model: grant follows request one cycle later
    always @(posedge clk) bgnt <= rst ? 1'b0 : breq;

    dmac_top #(.ADDR_W(AW), .CNT_W(16), .REG_W(RW)) dut_i (
        .clk(clk), .rst(rst), .cs_i(cs), .wr_i(wr), .sel_i(sel), .wdata_i(wdata),
        .rdata_o(rdata), .dreq_i(dreq), .dack_o(dack), .breq_o(breq), .bgnt_i(bgnt),
        .bus_oe_o(bus_oe), .mem_addr_o(mem_addr), .mem_wr_o(mem_wr), .mem_rd_o(mem_rd),
        .eot_irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    task automatic reg_wr(input logic [1:0] s, input logic [RW-1:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, output logic [RW-1:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b0; sel = s;
        #1 d = rdata;
        cs = 1'b0;
    endtask

    task automatic push_words(input logic [AW-1:0] base, input int n, input bit rd);
        for (int i = 0; i < n; i++) exp_q.push_back({rd, base + AW'(i)});
    endtask

    // monitor: compares each strobe with the next expected word
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_strobe && !tb_burst)
                chk(!breq, "R9 bus request gap after stolen word", breq, 0);
            if (mem_wr || mem_rd) begin
                logic [AW:0] e;
                words_seen++;
                chk(!(mem_wr && mem_rd), "R11 strobes exclusive", {mem_rd, mem_wr}, 1);
                chk(bus_oe == 1'b1 && bgnt, "R11 strobe while bus owned", bus_oe, 1);
                chk(dack, "R3/R4 acknowledge with strobe", dack, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected word", {mem_rd, mem_addr}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_addr == e[AW-1:0], "R4/R5 word address", mem_addr, e[AW-1:0]);
                    chk(mem_rd == e[AW], "R4 direction strobe", mem_rd, e[AW]);
                end
                if (tb_burst && prev_strobe)
                    chk(breq, "R8 burst holds request", breq, 1);
            end else begin
                chk(!dack, "R3 no acknowledge without word", dack, 0);
            end
            prev_strobe = mem_wr || mem_rd;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [RW-1:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        chk(!breq && !dack && !irq && !mem_wr && !mem_rd && !bus_oe, "R1 reset outputs",
            {breq, dack, irq, mem_wr, mem_rd}, 0);
        reg_rd(2'd0, d); chk(d == 0, "R1 reset address", d, 0);
        reg_rd(2'd2, d); chk(d == 0, "R1 reset control", d, 0);
        @(negedge clk); chk(rdata == 0, "R1 read without select", rdata, 0);

        // go with zero count ignored
        reg_wr(2'd2, 16'h0005);
        repeat (4) @(negedge clk);
        chk(!breq, "R2 zero count no request", breq, 0);
        reg_rd(2'd2, d); chk(d[4] == 0, "R2 zero count not busy", d[4], 0);

        // burst into memory, request held
        tb_burst = 1'b1;
        reg_wr(2'd0, 16'h0100);
        reg_wr(2'd1, 16'd4);
        push_words(16'h0100, 4, 1'b0);
        dreq = 1'b1;
        reg_wr(2'd2, 16'h0005);
        reg_rd(2'd2, d); chk(d[4:1] == 4'b1010, "R1/R2 control readback busy", d[4:1], 4'b1010);
        wait (irq);
        @(negedge clk);
        chk(!breq, "R6 request dropped at end", breq, 0);
        reg_rd(2'd0, d); chk(d == 16'h0104, "R5 final address", d, 16'h0104);
        reg_rd(2'd1, d); chk(d == 0, "R5 final count", d, 0);
        reg_rd(2'd2, d); chk(d[4:3] == 2'b01, "R6 irq set busy clear", d[4:3], 2'b01);
        repeat (5) @(negedge clk);
        reg_wr(2'd0, 16'h0200);
        chk(irq, "R7 irq held across other writes", irq, 1);
        reg_wr(2'd2, 16'h0000);
        @(negedge clk);
        chk(!irq, "R7 control write clears irq", irq, 0);

        // cycle stealing out of memory
        tb_burst = 1'b0;
        reg_wr(2'd1, 16'd3);
        push_words(16'h0200, 3, 1'b1);
        reg_wr(2'd2, 16'h0003);
        wait (irq);
        @(negedge clk);
        chk(exp_q.size() == 0, "R9 stolen words all seen", exp_q.size(), 0);
        reg_rd(2'd0, d); chk(d == 16'h0203, "R5 steal final address", d, 16'h0203);
        reg_wr(2'd2, 16'h0000);

        // burst with request withdrawn after two words
        tb_burst = 1'b1;
        words_seen = 0;
        reg_wr(2'd0, 16'h0300);
        reg_wr(2'd1, 16'd5);
        push_words(16'h0300, 5, 1'b0);
        reg_wr(2'd2, 16'h0005);
        wait (words_seen == 2);
        dreq = 1'b0;
        repeat (20) @(negedge clk);
        chk(words_seen == 2, "R10 no word without request", words_seen, 2);
        chk(!breq, "R10 request released", breq, 0);
        reg_wr(2'd0, 16'hFFFF);
        reg_wr(2'd1, 16'd7);
        reg_wr(2'd2, 16'h0003);
        reg_rd(2'd0, d); chk(d == 16'h0302, "R12 address write ignored", d, 16'h0302);
        reg_rd(2'd1, d); chk(d == 16'd3, "R10/R12 count held", d, 3);
        reg_rd(2'd2, d); chk(d[4:1] == 4'b1010, "R12 control write ignored", d[4:1], 4'b1010);
        dreq = 1'b1;
        wait (irq);
        @(negedge clk);
        chk(exp_q.size() == 0, "R8 remaining words seen", exp_q.size(), 0);
        chk(words_seen == 5, "R6 total words", words_seen, 5);
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule